// File: doc/BRIEF.md
# Card Identification State Machine

This block is the card-side controller that follows a memory card through power-up, identification and data transfer. A command deframer upstream hands it one decoded command at a time: a valid strobe, the 6-bit command index, the 32-bit argument and a flag that says whether the command CRC matched. The block returns the current bus state, a one-cycle request for the response type to send, the power-up-complete bit that goes with an operating-condition reply, and a 32-bit status word that carries the state code.

The states and their codes are idle (0), ready (1), identification (2), standby (3), transfer (4) and inactive (15). The transitions are as follows:
- A reset command (index 0) returns any state except inactive to idle.
- An operating-condition command (index 1) in idle polls the internal power-up. It goes to ready once power-up has finished, and to inactive if the voltage window does not match.
- A send-identity command (index 2) in ready starts a bitwise-arbitrated transfer on the shared line. When the transfer completes the card goes to identification. If the card loses arbitration it stays in ready.
- A set-address command (index 3) moves identification to standby and latches the card address.
- A select command (index 7) moves standby to transfer when the address matches. In transfer, a select with any other address moves the card back to standby.

Only the reset input (a power cycle) leaves inactive.

Top module: `card_id_fsm`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the state is idle (code 0), `rsp_valid` is 0 and the status word is zero.
- R2: An accepted index-0 command moves idle, ready, identification, standby or transfer to idle, sends no response and clears the stored address to 0. In inactive it has no effect.
- R3: An index-1 command in idle whose argument shares at least one bit with `VOLT_MASK` requests an R3 response. On the first `BUSY_POLLS` such polls since `rst_n` the state stays idle and `ocr_pwr_up` is 0. On every later poll `ocr_pwr_up` is 1 and the state becomes ready.
- R4: An index-1 command in idle whose argument shares no bit with `VOLT_MASK` moves the card to inactive without a response. Inactive ignores every command and is left only through `rst_n`.
- R5: An index-2 command in ready requests an R2 response and leaves the state in ready with a transfer pending. A `cid_done` pulse while the transfer is pending moves the card to identification. An `arb_lost` pulse, or any later accepted command, cancels the pending transfer, and a `cid_done` after that has no effect.
- R6: An index-3 command in identification requests an R1 response, moves the card to standby and stores argument bits 31:16 as the card address.
- R7: An index-7 command whose argument bits 31:16 equal the stored address moves standby to transfer with an R1 response. In transfer, an index-7 command with a different address moves the card to standby without a response. Any other index-7 case is ignored.
- R8: A command presented with `cmd_crc_ok` = 0 changes no state and requests no response.
- R9: Indices other than 0, 1, 2, 3 and 7 are ignored, and so is a supported command in a state where it is not listed above. Ignored means no state change and no response.
- R10: Status bits 12:9 hold the current state code and all other status bits are 0.
- R11: A response request is a single-cycle `rsp_valid` pulse in the cycle after the command, with `rsp_type` 1 = R1, 2 = R2 and 3 = R3. The state change appears in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-cycle reset |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_crc_ok | input | 1 | Command CRC matched |
| cid_done | input | 1 | Identity transfer finished without losing arbitration |
| arb_lost | input | 1 | Identity transfer lost arbitration on the shared line |
| card_state | output | 4 | Current state code |
| status | output | 32 | Status word, state in bits 12:9 |
| rsp_valid | output | 1 | Response request pulse |
| rsp_type | output | 2 | Requested response format |
| ocr_pwr_up | output | 1 | Power-up-complete bit for an R3 reply |

## Verification
The bench targets the following cases:
- The poll count around `BUSY_POLLS`. A design off by one reports ready one poll early or one poll late.
- A second power-up poll after a reset command. A design that restarts the count stalls in idle.
- A `cid_done` arriving after lost arbitration. A design that keeps the pending flag advances to identification without winning.
- A select with an address that does not match while the card is in standby, which must not move the card.
- The inactive state, which must absorb reset commands until `rst_n` is applied.
- CRC-failed commands in several states. Each must leave both the state and the response lines quiet.

// File: rtl/card_id_pkg.sv
package card_id_pkg;
    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_READY    = 4'd1,
        ST_IDENT    = 4'd2,
        ST_STBY     = 4'd3,
        ST_TRAN     = 4'd4,
        ST_INACTIVE = 4'd15
    } card_state_e;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_R1   = 2'd1,
        RSP_R2   = 2'd2,
        RSP_R3   = 2'd3
    } rsp_kind_e;

    localparam logic [5:0] IDX_GO_IDLE  = 6'd0;
    localparam logic [5:0] IDX_OP_COND  = 6'd1;
    localparam logic [5:0] IDX_SEND_ID  = 6'd2;
    localparam logic [5:0] IDX_SET_ADDR = 6'd3;
    localparam logic [5:0] IDX_SELECT   = 6'd7;
endpackage

// File: rtl/cid_cmd_decode.sv
module cid_cmd_decode
    import card_id_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [5:0] cmd_index,
    input  logic       cmd_crc_ok,
    output logic       cmd_ok,
    output logic       is_go_idle,
    output logic       is_op_cond,
    output logic       is_send_id,
    output logic       is_set_addr,
    output logic       is_select
);
    // A CRC failure makes the command invisible to everything downstream.
    assign cmd_ok      = cmd_valid & cmd_crc_ok;
    assign is_go_idle  = cmd_ok & (cmd_index == IDX_GO_IDLE);
    assign is_op_cond  = cmd_ok & (cmd_index == IDX_OP_COND);
    assign is_send_id  = cmd_ok & (cmd_index == IDX_SEND_ID);
    assign is_set_addr = cmd_ok & (cmd_index == IDX_SET_ADDR);
    assign is_select   = cmd_ok & (cmd_index == IDX_SELECT);
endmodule

// File: rtl/cid_pwrup_cnt.sv
module cid_pwrup_cnt #(
    parameter int BUSY_POLLS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic poll,
    output logic done
);
    localparam int CW = $clog2(BUSY_POLLS + 1) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(BUSY_POLLS);

    logic [CW-1:0] cnt_q;

    // Saturating poll counter; only a power cycle restarts it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (poll && cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/card_id_fsm.sv
module card_id_fsm
    import card_id_pkg::*;
#(
    parameter int          BUSY_POLLS = 3,
    parameter logic [31:0] VOLT_MASK  = 32'h00FF_8000,
    parameter int          ADDR_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    input  logic        cmd_crc_ok,
    input  logic        cid_done,
    input  logic        arb_lost,
    output logic [3:0]  card_state,
    output logic [31:0] status,
    output logic        rsp_valid,
    output logic [1:0]  rsp_type,
    output logic        ocr_pwr_up
);
    localparam int ST_LSB = 9;
    localparam int ST_W   = 4;

    logic cmd_ok, is_go_idle, is_op_cond, is_send_id, is_set_addr, is_select;
    logic poll, pwr_done, volt_ok, addr_hit;

    card_state_e        st_q, st_d;
    logic [ADDR_W-1:0]  addr_q, addr_d;
    logic               pend_q, pend_d;
    rsp_kind_e          rsp_d;
    logic               pwr_d;

    cid_cmd_decode u_dec (
        .cmd_valid  (cmd_valid),
        .cmd_index  (cmd_index),
        .cmd_crc_ok (cmd_crc_ok),
        .cmd_ok     (cmd_ok),
        .is_go_idle (is_go_idle),
        .is_op_cond (is_op_cond),
        .is_send_id (is_send_id),
        .is_set_addr(is_set_addr),
        .is_select  (is_select)
    );

    cid_pwrup_cnt #(.BUSY_POLLS(BUSY_POLLS)) u_pwr (
        .clk  (clk),
        .rst_n(rst_n),
        .poll (poll),
        .done (pwr_done)
    );

    assign volt_ok  = |(cmd_arg & VOLT_MASK);
    assign addr_hit = (cmd_arg[31 -: ADDR_W] == addr_q);

    // Next state, address, pending transfer and response request.
    always_comb begin
        st_d   = st_q;
        addr_d = addr_q;
        pend_d = cmd_ok ? 1'b0 : pend_q;
        rsp_d  = RSP_NONE;
        pwr_d  = 1'b0;
        poll   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (is_go_idle) begin
                    addr_d = '0;
                end else if (is_op_cond) begin
                    if (!volt_ok) begin
                        st_d = ST_INACTIVE;
                    end else begin
                        poll  = 1'b1;
                        rsp_d = RSP_R3;
                        pwr_d = pwr_done;
                        if (pwr_done) st_d = ST_READY;
                    end
                end
            end
            ST_READY: begin
                if (is_go_idle) begin
                    st_d   = ST_IDLE;
                    addr_d = '0;
                end else if (is_send_id) begin
                    rsp_d  = RSP_R2;
                    pend_d = 1'b1;
                end else if (!cmd_ok && pend_q) begin
                    if (cid_done) begin
                        st_d   = ST_IDENT;
                        pend_d = 1'b0;
                    end else if (arb_lost) begin
                        pend_d = 1'b0;
                    end
                end
            end
            ST_IDENT: begin
                if (is_go_idle) begin
                    st_d   = ST_IDLE;
                    addr_d = '0;
                end else if (is_set_addr) begin
                    st_d   = ST_STBY;
                    addr_d = cmd_arg[31 -: ADDR_W];
                    rsp_d  = RSP_R1;
                end
            end
            ST_STBY: begin
                if (is_go_idle) begin
                    st_d   = ST_IDLE;
                    addr_d = '0;
                end else if (is_select && addr_hit) begin
                    st_d  = ST_TRAN;
                    rsp_d = RSP_R1;
                end
            end
            ST_TRAN: begin
                if (is_go_idle) begin
                    st_d   = ST_IDLE;
                    addr_d = '0;
                end else if (is_select && !addr_hit) begin
                    st_d = ST_STBY;
                end
            end
            ST_INACTIVE: begin
                st_d = ST_INACTIVE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
            pend_q <= pend_d;
        end
    end

    // Registered response outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_type   <= RSP_NONE;
            ocr_pwr_up <= 1'b0;
        end else begin
            rsp_valid  <= (rsp_d != RSP_NONE);
            rsp_type   <= rsp_d;
            ocr_pwr_up <= pwr_d;
        end
    end

    assign card_state = st_q;
    always_comb begin
        status = '0;
        status[ST_LSB +: ST_W] = st_q;
    end
endmodule

// File: rtl/card_id_fsm_chk.sv
module card_id_fsm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [5:0]  cmd_index,
    input logic        cmd_crc_ok,
    input logic        cid_done,
    input logic        arb_lost,
    input logic [3:0]  card_state,
    input logic [31:0] status,
    input logic        rsp_valid,
    input logic [1:0]  rsp_type,
    input logic        ocr_pwr_up
);
    p_inactive_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        card_state == 4'd15 |=> card_state == 4'd15);

    p_crc_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_crc_ok && !cid_done && !arb_lost) |=> ($stable(card_state) && !rsp_valid));

    p_ident_from_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (card_state == 4'd2 && $past(card_state) != 4'd2) |-> $past(card_state) == 4'd1);

    p_r3_after_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_type == 2'd3) |-> $past(cmd_valid && cmd_index == 6'd1));

    p_r3_ready_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_type == 2'd3) |-> (ocr_pwr_up ? card_state == 4'd1 : card_state == 4'd0));

    p_tran_from_stby_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (card_state == 4'd4 && $past(card_state) != 4'd4) |-> ($past(card_state) == 4'd3 && rsp_valid));

    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_type != 2'd0);

    always @(negedge clk) begin
        if (rst_n) begin
            p_status_field_r10: assert (status[12:9] == card_state && status[31:13] == '0 && status[8:0] == '0);
        end
    end
endmodule

bind card_id_fsm card_id_fsm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_index  (cmd_index),
    .cmd_crc_ok (cmd_crc_ok),
    .cid_done   (cid_done),
    .arb_lost   (arb_lost),
    .card_state (card_state),
    .status     (status),
    .rsp_valid  (rsp_valid),
    .rsp_type   (rsp_type),
    .ocr_pwr_up (ocr_pwr_up)
);

// File: tb/card_id_fsm_tb.sv
module card_id_fsm_tb;
    localparam int CLK_PERIOD = 10;
    localparam int POLLS      = 3;
    localparam logic [31:0] MASK = 32'h00FF_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        cmd_crc_ok = 1'b1;
    logic        cid_done = 1'b0;
    logic        arb_lost = 1'b0;
    logic [3:0]  card_state;
    logic [31:0] status;
    logic        rsp_valid;
    logic [1:0]  rsp_type;
    logic        ocr_pwr_up;

    card_id_fsm #(.BUSY_POLLS(POLLS), .VOLT_MASK(MASK)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .cmd_crc_ok(cmd_crc_ok), .cid_done(cid_done),
        .arb_lost(arb_lost), .card_state(card_state), .status(status),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .ocr_pwr_up(ocr_pwr_up)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model.
    int m_state, m_polls, m_addr, m_rv, m_rt, m_pwr;
    bit m_pend;
    int vectors = 0, errors = 0;
    string phase = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_polls = 0; m_addr = 0; m_pend = 0; m_rv = 0; m_rt = 0; m_pwr = 0;
        end else begin
            bit ok;
            ok = cmd_valid && cmd_crc_ok;
            m_rv = 0; m_rt = 0; m_pwr = 0;
            if (m_state != 15) begin
                if (ok && cmd_index == 0) begin
                    m_state = 0; m_addr = 0; m_pend = 0;
                end else if (ok) begin
                    m_pend = 0;
                    if (cmd_index == 1 && m_state == 0) begin
                        if ((cmd_arg & MASK) == 0) m_state = 15;
                        else begin
                            m_rv = 1; m_rt = 3;
                            if (m_polls >= POLLS) begin m_pwr = 1; m_state = 1; end
                            else m_polls++;
                        end
                    end else if (cmd_index == 2 && m_state == 1) begin
                        m_rv = 1; m_rt = 2; m_pend = 1;
                    end else if (cmd_index == 3 && m_state == 2) begin
                        m_rv = 1; m_rt = 1; m_state = 3; m_addr = cmd_arg[31:16];
                    end else if (cmd_index == 7 && m_state == 3 && cmd_arg[31:16] == m_addr) begin
                        m_rv = 1; m_rt = 1; m_state = 4;
                    end else if (cmd_index == 7 && m_state == 4 && cmd_arg[31:16] != m_addr) begin
                        m_state = 3;
                    end
                end else if (m_state == 1 && m_pend) begin
                    if (cid_done) begin m_state = 2; m_pend = 0; end
                    else if (arb_lost) m_pend = 0;
                end
            end
        end
    end

    task automatic check(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
        end
    endtask

    // Compare on every falling edge.
    always @(negedge clk) begin
        check("state", card_state, m_state);
        check("status R10", status, m_state << 9);
        check("rsp_valid R11", rsp_valid, m_rv);
        if (m_rv) check("rsp_type R11", rsp_type, m_rt);
        if (m_rv && m_rt == 3) check("ocr_pwr_up", ocr_pwr_up, m_pwr);
    end

    task automatic send(int idx, logic [31:0] arg, bit crc = 1'b1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_index = 6'(idx); cmd_arg = arg; cmd_crc_ok = crc;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_crc_ok = 1'b1;
    endtask

    task automatic pulse(bit done_not_lost);
        @(negedge clk);
        if (done_not_lost) cid_done = 1'b1; else arb_lost = 1'b1;
        @(negedge clk);
        cid_done = 1'b0; arb_lost = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int wd = 0;
        while (wd < 5000) begin @(posedge clk); wd++; end
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        phase = "R1"; do_reset(); repeat (2) @(negedge clk);
        phase = "R9"; send(9, 32'h0); send(3, 32'h1234_0000); send(7, 32'h0);
        phase = "R8"; send(1, MASK, 1'b0);
        phase = "R3"; for (int i = 0; i <= POLLS; i++) send(1, MASK);
        phase = "R2"; send(0, 32'h0);
        phase = "R3"; send(1, 32'h0000_8000);
        phase = "R5"; send(2, 32'h0); pulse(1'b0); pulse(1'b1);
        send(2, 32'h0); send(9, 32'h0); pulse(1'b1);
        send(2, 32'h0); pulse(1'b1);
        phase = "R6"; send(3, 32'h1234_0000);
        phase = "R7"; send(7, 32'h5555_0000); send(7, 32'h1234_0000);
        send(7, 32'h1234_0000); send(7, 32'h0001_0000);
        phase = "R8"; send(0, 32'h0, 1'b0); send(7, 32'h1234_0000, 1'b0);
        phase = "R2"; send(7, 32'h1234_0000); send(0, 32'h0);
        phase = "R7"; send(1, MASK); send(2, 32'h0); pulse(1'b1);
        send(3, 32'h0); send(7, 32'h1234_0000); send(7, 32'h0000_0000);
        phase = "R4"; send(0, 32'h0); send(1, 32'h0000_0100);
        send(0, 32'h0); send(1, MASK); send(2, 32'h0); pulse(1'b1);
        phase = "R1"; do_reset(); repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule